// File: doc/BRIEF.md
# Raster Timing Generator

This block produces horizontal sync, vertical sync, a data-enable strobe and a field flag for a raster display pipeline. Each axis is described by its active size, its blanking length, and the position and width of its sync pulse. The sync position is measured from the end of active video. A line lasts active plus blanking pixels. A field lasts active plus blanking lines. The polarity of each of the three outputs is chosen on its own.

Interlaced output toggles a field flag on each field. An optional fractional-blanking setting gives the odd field one extra blanking line, so successive fields alternate between N and N+1 blanking lines. The timing inputs are captured into a shadow copy only at a field boundary, so every field is produced with one consistent set of parameters. The block also drives three constant minimum control-period durations for a downstream encoder.

A legal setting has active and blanking sizes of at least one on both axes. The sync offset plus the sync width must fit inside the blanking on each axis.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_n is low, hsync_o, vsync_o, de_o, field_o and frame_start_o are all 0.
- R2: Each line lasts h_active + h_blank pixel clocks, and de_o is active on the first h_active pixels of every active line, beginning with the frame_start_o cycle.
- R3: Counting the first pixel of a line as 0, hsync_o is active from pixel h_active + h_sync_dly for exactly h_sync_wid pixels.
- R4: A field lasts v_active + v_blank lines. Counting the first line as 0, vsync_o is active for whole lines from line v_active + v_sync_dly for exactly v_sync_wid lines.
- R5: de_o is active only where both the pixel and the line counters are inside their active regions: exactly v_active lines carry data, and de_o is never active together with an active sync.
- R6: Each polarity bit set to 1 makes its output active-high; set to 0, the output is active-low. The three bits act independently.
- R7: With interlace set, field_o toggles at every field start. With interlace clear, field_o is 0. The first field after reset has field_o = 0.
- R8: With interlace and frac_vblank both set, a field with field_o = 1 has v_blank + 1 blanking lines and a field with field_o = 0 has v_blank. With interlace clear, frac_vblank has no effect.
- R9: The inputs present at the clock edge that ends a field govern the whole next field. A change made in the middle of a field does not alter that field.
- R10: ctl_min_o, ctl_ext_min_o and ctl_ext_space_o read 12, 32 and 1 with the default parameters.
- R11: frame_start_o is a one-cycle pulse in the first pixel of each field, aligned with the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_active | input | 16 | Active pixels per line |
| h_blank | input | 16 | Blanking pixels per line |
| h_sync_dly | input | 16 | Pixels from end of active to hsync start |
| h_sync_wid | input | 16 | Hsync width in pixels |
| v_active | input | 16 | Active lines per field |
| v_blank | input | 8 | Blanking lines per field (base value) |
| v_sync_dly | input | 8 | Lines from end of active to vsync start |
| v_sync_wid | input | 8 | Vsync width in lines |
| hs_pol | input | 1 | 1 = hsync active-high |
| vs_pol | input | 1 | 1 = vsync active-high |
| de_pol | input | 1 | 1 = data-enable active-high |
| interlace | input | 1 | 1 = interlaced fields |
| frac_vblank | input | 1 | 1 = odd fields get one extra blanking line (interlaced only) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field parity |
| frame_start_o | output | 1 | Pulse in the first pixel of each field |
| ctl_min_o | output | 8 | Minimum control-period length |
| ctl_ext_min_o | output | 8 | Minimum extended control-period length |
| ctl_ext_space_o | output | 8 | Extended control-period spacing |

## Verification
The counters and the output stage are each one register deep. Every output therefore describes the raster position reached one clock earlier, and all outputs, including frame_start_o, move together. The shadow copy of the inputs loads on the edge where the last pixel of a field wraps. The new values therefore first show in the frame_start_o cycle of the next field. The bench measures every quantity as an offset in clock cycles from a frame_start_o pulse, sampled on the falling edge. Each expected field is queued before its pulse and popped at that pulse. Inputs are changed just after a pulse, so the field in progress must keep the timing queued for it.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    // Input field widths
    localparam int unsigned H_W  = 16;
    localparam int unsigned VA_W = 16;
    localparam int unsigned VB_W = 8;
    // Counter widths: sum of active and blanking (plus one extra line)
    localparam int unsigned HC_W = H_W + 1;
    localparam int unsigned VC_W = VA_W + 1;

    typedef struct packed {
        logic [H_W-1:0]  h_act;
        logic [H_W-1:0]  h_blank;
        logic [H_W-1:0]  h_sdly;
        logic [H_W-1:0]  h_swid;
        logic [VA_W-1:0] v_act;
        logic [VB_W-1:0] v_blank;
        logic [VB_W-1:0] v_sdly;
        logic [VB_W-1:0] v_swid;
        logic            hs_pol;
        logic            vs_pol;
        logic            de_pol;
        logic            interlace;
        logic            frac_vb;
    } rtg_cfg_t;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
    import rtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  rtg_cfg_t cfg_i,
    output rtg_cfg_t cfg_o
);
    rtg_cfg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) sh_d = cfg_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign cfg_o = sh_q;

    // Parameters in use change only at a field boundary
    assert_hold_midfield_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(sh_q));
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [H_W-1:0]  h_act_i,
    input  logic [H_W-1:0]  h_blank_i,
    input  logic [VA_W-1:0] v_act_i,
    input  logic [VB_W-1:0] v_blank_i,
    input  logic            interlace_i,
    input  logic            frac_vb_i,
    input  logic            next_interlace_i,
    output logic            run_o,
    output logic [HC_W-1:0] h_o,
    output logic [VC_W-1:0] v_o,
    output logic            field_o,
    output logic            load_o
);
    typedef struct packed {
        logic            run;
        logic [HC_W-1:0] h;
        logic [VC_W-1:0] v;
        logic            field;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [HC_W-1:0] htot;
    logic [VC_W-1:0] vtot;
    logic            extra_line;
    logic            h_last, v_last;
    logic            load;

    always_comb begin
        extra_line = interlace_i & frac_vb_i & s_q.field;
        htot   = HC_W'(h_act_i) + HC_W'(h_blank_i);
        vtot   = VC_W'(v_act_i) + VC_W'(v_blank_i) + VC_W'(extra_line);
        h_last = s_q.h >= (htot - HC_W'(1));
        v_last = s_q.v >= (vtot - VC_W'(1));
        s_d    = s_q;
        load   = 1'b0;
        if (!s_q.run) begin
            s_d.run   = 1'b1;
            s_d.h     = '0;
            s_d.v     = '0;
            s_d.field = 1'b0;
            load      = 1'b1;
        end else if (h_last) begin
            s_d.h = '0;
            if (v_last) begin
                s_d.v     = '0;
                s_d.field = next_interlace_i ? ~s_q.field : 1'b0;
                load      = 1'b1;
            end else begin
                s_d.v = s_q.v + VC_W'(1);
            end
        end else begin
            s_d.h = s_q.h + HC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o   = s_q.run;
    assign h_o     = s_q.h;
    assign v_o     = s_q.v;
    assign field_o = s_q.field;
    assign load_o  = load;

    // Line counter moves only at the start of a line
    assert_line_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.h != '0) |-> $stable(s_q.v));
    // Progressive fields always report parity 0
    assert_prog_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !interlace_i) |-> !s_q.field);
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [HC_W-1:0] h_i,
    input  logic [VC_W-1:0] v_i,
    input  logic            field_i,
    input  logic [H_W-1:0]  h_act_i,
    input  logic [H_W-1:0]  h_sdly_i,
    input  logic [H_W-1:0]  h_swid_i,
    input  logic [VA_W-1:0] v_act_i,
    input  logic [VB_W-1:0] v_sdly_i,
    input  logic [VB_W-1:0] v_swid_i,
    input  logic            hs_pol_i,
    input  logic            vs_pol_i,
    input  logic            de_pol_i,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            de_o,
    output logic            field_o,
    output logic            frame_start_o
);
    localparam int unsigned HX_W = HC_W + 1;
    localparam int unsigned VX_W = VC_W + 1;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic field;
        logic fs;
    } out_t;

    out_t o_d, o_q;
    logic [HX_W-1:0] hs_start, hs_end, hx;
    logic [VX_W-1:0] vs_start, vs_end, vx;
    logic de_raw, hs_raw, vs_raw;

    always_comb begin
        hx       = HX_W'(h_i);
        vx       = VX_W'(v_i);
        hs_start = HX_W'(h_act_i) + HX_W'(h_sdly_i);
        hs_end   = hs_start + HX_W'(h_swid_i);
        vs_start = VX_W'(v_act_i) + VX_W'(v_sdly_i);
        vs_end   = vs_start + VX_W'(v_swid_i);
        de_raw   = run_i && (h_i < HC_W'(h_act_i)) && (v_i < VC_W'(v_act_i));
        hs_raw   = run_i && (hx >= hs_start) && (hx < hs_end);
        vs_raw   = run_i && (vx >= vs_start) && (vx < vs_end);
        o_d.hs    = run_i & (hs_raw ^ ~hs_pol_i);
        o_d.vs    = run_i & (vs_raw ^ ~vs_pol_i);
        o_d.de    = run_i & (de_raw ^ ~de_pol_i);
        o_d.field = run_i & field_i;
        o_d.fs    = run_i && (h_i == '0) && (v_i == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hsync_o       = o_q.hs;
    assign vsync_o       = o_q.vs;
    assign de_o          = o_q.de;
    assign field_o       = o_q.field;
    assign frame_start_o = o_q.fs;

    // Data never overlaps a horizontal or a vertical sync
    assert_de_no_hsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !hs_raw);
    assert_de_no_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> !vs_raw);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CTL_W         = 8,
    parameter int unsigned CTL_MIN       = 12,
    parameter int unsigned CTL_EXT_MIN   = 32,
    parameter int unsigned CTL_EXT_SPACE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [H_W-1:0]   h_active,
    input  logic [H_W-1:0]   h_blank,
    input  logic [H_W-1:0]   h_sync_dly,
    input  logic [H_W-1:0]   h_sync_wid,
    input  logic [VA_W-1:0]  v_active,
    input  logic [VB_W-1:0]  v_blank,
    input  logic [VB_W-1:0]  v_sync_dly,
    input  logic [VB_W-1:0]  v_sync_wid,
    input  logic             hs_pol,
    input  logic             vs_pol,
    input  logic             de_pol,
    input  logic             interlace,
    input  logic             frac_vblank,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             field_o,
    output logic             frame_start_o,
    output logic [CTL_W-1:0] ctl_min_o,
    output logic [CTL_W-1:0] ctl_ext_min_o,
    output logic [CTL_W-1:0] ctl_ext_space_o
);
    rtg_cfg_t        cfg_in, cfg_sh;
    logic            load, run, field;
    logic [HC_W-1:0] h_pos;
    logic [VC_W-1:0] v_pos;

    always_comb begin
        cfg_in.h_act     = h_active;
        cfg_in.h_blank   = h_blank;
        cfg_in.h_sdly    = h_sync_dly;
        cfg_in.h_swid    = h_sync_wid;
        cfg_in.v_act     = v_active;
        cfg_in.v_blank   = v_blank;
        cfg_in.v_sdly    = v_sync_dly;
        cfg_in.v_swid    = v_sync_wid;
        cfg_in.hs_pol    = hs_pol;
        cfg_in.vs_pol    = vs_pol;
        cfg_in.de_pol    = de_pol;
        cfg_in.interlace = interlace;
        cfg_in.frac_vb   = frac_vblank;
    end

    rtg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg_sh)
    );

    rtg_counter u_counter (
        .clk              (clk),
        .rst_n            (rst_n),
        .h_act_i          (cfg_sh.h_act),
        .h_blank_i        (cfg_sh.h_blank),
        .v_act_i          (cfg_sh.v_act),
        .v_blank_i        (cfg_sh.v_blank),
        .interlace_i      (cfg_sh.interlace),
        .frac_vb_i        (cfg_sh.frac_vb),
        .next_interlace_i (interlace),
        .run_o            (run),
        .h_o              (h_pos),
        .v_o              (v_pos),
        .field_o          (field),
        .load_o           (load)
    );

    rtg_decode u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (run),
        .h_i           (h_pos),
        .v_i           (v_pos),
        .field_i       (field),
        .h_act_i       (cfg_sh.h_act),
        .h_sdly_i      (cfg_sh.h_sdly),
        .h_swid_i      (cfg_sh.h_swid),
        .v_act_i       (cfg_sh.v_act),
        .v_sdly_i      (cfg_sh.v_sdly),
        .v_swid_i      (cfg_sh.v_swid),
        .hs_pol_i      (cfg_sh.hs_pol),
        .vs_pol_i      (cfg_sh.vs_pol),
        .de_pol_i      (cfg_sh.de_pol),
        .hsync_o       (hsync_o),
        .vsync_o       (vsync_o),
        .de_o          (de_o),
        .field_o       (field_o),
        .frame_start_o (frame_start_o)
    );

    assign ctl_min_o       = CTL_W'(CTL_MIN);
    assign ctl_ext_min_o   = CTL_W'(CTL_EXT_MIN);
    assign ctl_ext_space_o = CTL_W'(CTL_EXT_SPACE);

    // Field start marker lasts a single pixel
    assert_fs_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_active = '0, h_blank = '0, h_sync_dly = '0, h_sync_wid = '0, v_active = '0;
    logic [7:0]  v_blank = '0, v_sync_dly = '0, v_sync_wid = '0;
    logic        hs_pol = 1'b1, vs_pol = 1'b1, de_pol = 1'b1, interlace = 1'b0, frac_vblank = 1'b0;
    logic        hsync_o, vsync_o, de_o, field_o, frame_start_o;
    logic [7:0]  ctl_min_o, ctl_ext_min_o, ctl_ext_space_o;

    always #10 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .h_active(h_active), .h_blank(h_blank), .h_sync_dly(h_sync_dly), .h_sync_wid(h_sync_wid),
        .v_active(v_active), .v_blank(v_blank), .v_sync_dly(v_sync_dly), .v_sync_wid(v_sync_wid),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol), .interlace(interlace),
        .frac_vblank(frac_vblank),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
        .frame_start_o(frame_start_o),
        .ctl_min_o(ctl_min_o), .ctl_ext_min_o(ctl_ext_min_o), .ctl_ext_space_o(ctl_ext_space_o)
    );

    typedef struct {
        int    htot, total, de_cnt, de_lines, hs_first, hs_cnt, vs_first, vs_cnt;
        bit    field, hp, vp, dp;
        string len_tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_errors = 0, n_pushed = 0, n_done = 0;
    bit   cur_field = 1'b0, changed = 1'b0, finished = 1'b0;

    task automatic check(string tag, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic set_mode(int ha, int hb, int hd, int hw, int va, int vb, int vd, int vw,
                            bit hp, bit vp, bit dp, bit il, bit fr);
        changed = (h_active != 16'(ha)) || (h_blank != 16'(hb)) || (v_blank != 8'(vb))
                  || (interlace != il) || (frac_vblank != fr) || (hs_pol != hp);
        h_active = 16'(ha); h_blank = 16'(hb); h_sync_dly = 16'(hd); h_sync_wid = 16'(hw);
        v_active = 16'(va); v_blank = 8'(vb); v_sync_dly = 8'(vd); v_sync_wid = 8'(vw);
        hs_pol = hp; vs_pol = vp; de_pol = dp; interlace = il; frac_vblank = fr;
    endtask

    // Expected summary of the field governed by the current inputs
    task automatic push_exp();
        exp_t e;
        int vtot;
        e.htot     = int'(h_active) + int'(h_blank);
        vtot       = int'(v_active) + int'(v_blank) + ((interlace && frac_vblank && cur_field) ? 1 : 0);
        e.total    = e.htot * vtot;
        e.de_cnt   = int'(h_active) * int'(v_active);
        e.de_lines = int'(v_active);
        e.hs_first = int'(h_active) + int'(h_sync_dly);
        e.hs_cnt   = int'(h_sync_wid);
        e.vs_first = (int'(v_active) + int'(v_sync_dly)) * e.htot;
        e.vs_cnt   = int'(v_sync_wid) * e.htot;
        e.field = cur_field; e.hp = hs_pol; e.vp = vs_pol; e.dp = de_pol;
        if (frac_vblank)  e.len_tag = "R8 field length";
        else if (changed) e.len_tag = "R9 field length after change";
        else              e.len_tag = "R11 frame_start spacing";
        exp_q.push_back(e);
        n_pushed++;
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start_o);
    endtask

    // Apply the inputs for the next field right after a field start (R9)
    task automatic step(int ha, int hb, int hd, int hw, int va, int vb, int vd, int vw,
                        bit hp, bit vp, bit dp, bit il, bit fr);
        wait_fs();
        repeat (3) @(negedge clk);
        set_mode(ha, hb, hd, hw, va, vb, vd, vw, hp, vp, dp, il, fr);
        cur_field = il ? ~cur_field : 1'b0;
        push_exp();
    endtask

    // Monitor: measure each field and compare with the queued expectation
    initial begin
        exp_t cur;
        bit   have = 1'b0;
        int   c = 0, de_cnt = 0, de_lines = 0, hs_first = -1, hs_cnt = 0;
        int   vs_first = -1, vs_cnt = 0, overlap = 0;
        forever begin
            @(negedge clk);
            if (rst_n && frame_start_o) begin
                if (have) begin
                    check(cur.len_tag, c, cur.total);
                    check("R2 data pixels", de_cnt, cur.de_cnt);
                    check("R5 data lines", de_lines, cur.de_lines);
                    check("R3 hsync start", hs_first, cur.hs_first);
                    check("R3 hsync width", hs_cnt, cur.hs_cnt);
                    check("R4 vsync start", vs_first, cur.vs_first);
                    check("R4 vsync width", vs_cnt, cur.vs_cnt);
                    check("R5 data during sync", overlap, 0);
                    n_done++;
                end
                have = 1'b0;
                if (exp_q.size() > 0) begin
                    cur = exp_q.pop_front();
                    have = 1'b1;
                    c = 0; de_cnt = 0; de_lines = 0; hs_first = -1; hs_cnt = 0;
                    vs_first = -1; vs_cnt = 0; overlap = 0;
                    check("R7 field parity", int'(field_o), int'(cur.field));
                    check("R6 hsync idle level", int'(hsync_o), int'(!cur.hp));
                    check("R6 data level at start", int'(de_o), int'(cur.dp));
                end
            end
            if (have) begin
                bit ha_, va_, da_;
                ha_ = (hsync_o == cur.hp);
                va_ = (vsync_o == cur.vp);
                da_ = (de_o == cur.dp);
                if (da_) de_cnt++;
                if (da_ && (c % cur.htot) == 0) de_lines++;
                if (c < cur.htot && ha_) begin
                    hs_cnt++;
                    if (hs_first < 0) hs_first = c;
                end
                if (va_) begin
                    vs_cnt++;
                    if (vs_first < 0) vs_first = c;
                end
                if (da_ && (ha_ || va_)) overlap++;
                c++;
            end
        end
    end

    // Driver
    initial begin
        set_mode(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 0, 0);
        cur_field = 1'b0;
        changed = 1'b0;
        push_exp();
        repeat (4) @(negedge clk);
        check("R1 hsync in reset", int'(hsync_o), 0);
        check("R1 vsync in reset", int'(vsync_o), 0);
        check("R1 de in reset", int'(de_o), 0);
        check("R1 field in reset", int'(field_o), 0);
        check("R1 frame_start in reset", int'(frame_start_o), 0);
        check("R10 control minimum", int'(ctl_min_o), 12);
        check("R10 extended minimum", int'(ctl_ext_min_o), 32);
        check("R10 extended spacing", int'(ctl_ext_space_o), 1);
        rst_n = 1'b1;
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 0, 0);
        step(8, 6, 2, 3, 4, 3, 1, 2, 0, 1, 0, 0, 0);   // mixed polarities (R6)
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 0, 1, 1, 0);   // interlace (R7)
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 0, 1, 1, 0);
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 1, 1);   // fractional blanking (R8)
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 1, 1);
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 1, 1);
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 0, 1);   // fractional ignored, progressive
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 0, 1);
        step(5, 4, 0, 4, 3, 2, 0, 2, 0, 0, 0, 0, 0);   // sync fills blanking
        step(5, 4, 0, 4, 3, 2, 0, 2, 1, 1, 1, 1, 1);
        step(5, 4, 0, 4, 3, 2, 0, 2, 1, 1, 1, 1, 1);
        step(8, 6, 2, 3, 4, 3, 1, 2, 1, 1, 1, 0, 0);
        while (n_done < n_pushed) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d fields", n_done, n_pushed);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule